// File: doc/BRIEF.md
# Workspace Context Switch Sequencer

This block performs the multi-cycle context switches of a processor whose general registers live in memory. The current register set is found through a workspace pointer (WP): register n sits at byte address WP + 2n, and each register is one 16-bit word. The block holds the architectural program counter (PC), workspace pointer and status word (ST). It drives a simple word-wide memory port with an address, a read strobe, a write strobe, write data, read data and a ready handshake.

A one-cycle `start_i` pulse launches a sequence. `op_i` selects the sequence, `addr_i` carries an operand address and `cnt_i` carries a 4-bit count or interrupt level. Six sequences exist.

- Vectored switches (workspace swap, extended operation, interrupt entry and restart) first read a two-word vector: the new WP, then the new PC. They then write the old WP, PC and ST into registers 13, 14 and 15 of the new workspace.
- Return reads those three registers back from the current workspace.
- Call-with-link stores the PC into register 11 and jumps.

`done_o` pulses for one cycle when the new PC, WP and ST take effect. Instruction decode, arithmetic and interrupt arbitration sit outside the block.

States and transitions:

| State | Access | Next state |
|---|---|---|
| `S_IDLE` | none | an accepted start goes to `S_VEC_WP` (vectored switches), `S_LD_WP` (return) or `S_LINK` (call) |
| `S_VEC_WP` | read | `S_VEC_PC` |
| `S_VEC_PC` | read | `S_SV_WP` |
| `S_SV_WP` | write | `S_SV_PC` |
| `S_SV_PC` | write | `S_SV_ST` |
| `S_SV_ST` | write | `S_SV_LINK` for an extended operation, otherwise `S_COMMIT` |
| `S_SV_LINK` | write | `S_COMMIT` |
| `S_LD_WP` | read | `S_LD_PC` |
| `S_LD_PC` | read | `S_LD_ST` |
| `S_LD_ST` | read | `S_COMMIT` |
| `S_LINK` | write | `S_COMMIT` |
| `S_COMMIT` | none (asserts done) | `S_IDLE` |

Every memory state advances only on a cycle with `mem_ready_i` high.

Top module: `wsctx_seq`

## Requirements
- R1: After reset, PC, WP and ST are zero, both memory strobes are low, and busy and done are low.
- R2: Op code 0 (workspace swap) reads the new WP from address s, then the new PC from address s+2, where s is `addr_i`. ST is unchanged.
- R3: After its two vector reads, every vectored switch writes the old WP, the old PC and the old ST, in that order, to new WP + 26, + 28 and + 30.
- R4: Op code 1 (return) reads WP + 26, WP + 28 and WP + 30 of the current workspace, in that order. It then loads WP, PC and ST from those three words.
- R5: Op code 2 (extended operation, count c) takes its vector from 0x0040 + 4c and 0x0042 + 4c. After the three saves it writes `addr_i` to new WP + 22. It sets ST bit 9 and keeps every other ST bit.
- R6: Op code 3 (interrupt, level k) takes its vector from 4k and 4k + 2. It sets ST[3:0] to k − 1, or to 0 when k is 0, and keeps ST[15:4].
- R7: Op code 4 (restart) takes its vector from 0xFFFC and 0xFFFE and leaves ST unchanged.
- R8: Op code 5 (call with link) writes the current PC to WP + 22, then sets PC to `addr_i`. WP and ST are unchanged.
- R9: While an access waits with `mem_ready_i` low, the address, the strobe and the write data hold steady.
- R10: `done_o` is high for exactly one cycle. PC, WP and ST change only at the clock edge that ends that cycle.
- R11: A start pulse during a running sequence, or with op code 6 or 7, causes no memory access, no done pulse and no register change.
- R12: The read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle launch pulse |
| op_i | input | 3 | Sequence select (0 to 5) |
| addr_i | input | 16 | Operand address s |
| cnt_i | input | 4 | Extended-operation count or interrupt level |
| mem_addr_o | output | 16 | Byte address of the current access |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, taken when ready is high |
| mem_ready_i | input | 1 | Completes the current access |
| pc_o | output | 16 | Program counter |
| wp_o | output | 16 | Workspace pointer |
| st_o | output | 16 | Status word |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
A wrong state or a wrong transition shows up at the memory port on the very next access, as a wrong address, a wrong strobe kind or a missing save. The scoreboard therefore compares each access against the expected sequence at the moment it is granted. A wrongly latched vector word or operand first appears as a wrong save address. Otherwise it appears as a wrong PC, WP or ST in the cycle after the done pulse, and a later return sequence repeats the error. Wait states are inserted in a rotating pattern so that a state that advances without ready breaks the expected order within one access.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    typedef enum logic [2:0] {
        OP_SWAP_WS  = 3'd0,
        OP_RETURN   = 3'd1,
        OP_EXTOP    = 3'd2,
        OP_IRQ      = 3'd3,
        OP_RESTART  = 3'd4,
        OP_CALL     = 3'd5
    } ctx_op_e;

    localparam logic [2:0] OP_LAST = 3'd5;

    typedef enum logic [3:0] {
        S_IDLE,
        S_VEC_WP,
        S_VEC_PC,
        S_SV_WP,
        S_SV_PC,
        S_SV_ST,
        S_SV_LINK,
        S_LD_WP,
        S_LD_PC,
        S_LD_ST,
        S_LINK,
        S_COMMIT
    } ctx_state_e;

    // status word layout used by the sequencer
    localparam int ST_XOP_BIT = 9;
    localparam int MASK_W     = 4;

endpackage

// File: rtl/ctx_vector.sv
module ctx_vector
    import ctx_pkg::*;
#(
    parameter int            W         = 16,
    parameter int            CNT_W     = 4,
    parameter logic [W-1:0]  XOP_BASE  = 16'h0040,
    parameter logic [W-1:0]  IRQ_BASE  = 16'h0000,
    parameter logic [W-1:0]  RESTART_V = 16'hFFFC
) (
    input  logic [2:0]       op_i,
    input  logic [W-1:0]     opnd_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [W-1:0]     vec_o
);

    // each vector entry is two words, four bytes
    logic [W-1:0] slot_off;
    assign slot_off = W'({cnt_i, 2'b00});

    always_comb begin
        if (op_i == OP_EXTOP)
            vec_o = XOP_BASE + slot_off;
        else if (op_i == OP_IRQ)
            vec_o = IRQ_BASE + slot_off;
        else if (op_i == OP_RESTART)
            vec_o = RESTART_V;
        else
            vec_o = opnd_i;
    end

endmodule

// File: rtl/ctx_arch_regs.sv
module ctx_arch_regs #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit_i,
    input  logic [W-1:0] new_pc_i,
    input  logic [W-1:0] new_wp_i,
    input  logic [W-1:0] new_st_i,
    output logic [W-1:0] pc_o,
    output logic [W-1:0] wp_o,
    output logic [W-1:0] st_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_o <= '0;
            wp_o <= '0;
            st_o <= '0;
        end else if (commit_i) begin
            pc_o <= new_pc_i;
            wp_o <= new_wp_i;
            st_o <= new_st_i;
        end
    end

endmodule

// File: rtl/ctx_seq_fsm.sv
module ctx_seq_fsm
    import ctx_pkg::*;
#(
    parameter int W        = 16,
    parameter int CNT_W    = 4,
    parameter int LINK_REG = 11,
    parameter int SAVE_REG = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       op_i,
    input  logic [W-1:0]     opnd_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [W-1:0]     vec_i,
    input  logic [W-1:0]     pc_i,
    input  logic [W-1:0]     wp_i,
    input  logic [W-1:0]     st_i,
    input  logic [W-1:0]     mem_rdata_i,
    input  logic             mem_ready_i,
    output logic [W-1:0]     mem_addr_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic [W-1:0]     mem_wdata_o,
    output logic             commit_o,
    output logic [W-1:0]     new_pc_o,
    output logic [W-1:0]     new_wp_o,
    output logic [W-1:0]     new_st_o,
    output logic             busy_o
);

    localparam logic [W-1:0] OFF_LINK = W'(2 * LINK_REG);
    localparam logic [W-1:0] OFF_SWP  = W'(2 * SAVE_REG);
    localparam logic [W-1:0] OFF_SPC  = W'(2 * (SAVE_REG + 1));
    localparam logic [W-1:0] OFF_SST  = W'(2 * (SAVE_REG + 2));

    ctx_state_e   state, nxt;
    ctx_op_e      op_q;
    logic [W-1:0] opnd_q, vec_q, nwp_q, npc_q, nst_q;
    logic [W-1:0] st_calc;
    logic [MASK_W-1:0] irq_mask;
    logic         accept;

    assign accept = (state == S_IDLE) && start_i && (op_i <= OP_LAST);

    // new interrupt mask is one below the accepted level, floor zero
    assign irq_mask = (cnt_i == '0) ? '0 : MASK_W'(cnt_i - 1'b1);

    always_comb begin
        st_calc = st_i;
        if (op_i == OP_EXTOP)
            st_calc[ST_XOP_BIT] = 1'b1;
        else if (op_i == OP_IRQ)
            st_calc[MASK_W-1:0] = irq_mask;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    if (op_i == OP_RETURN)    nxt = S_LD_WP;
                    else if (op_i == OP_CALL) nxt = S_LINK;
                    else                      nxt = S_VEC_WP;
                end
            end
            S_VEC_WP:  if (mem_ready_i) nxt = S_VEC_PC;
            S_VEC_PC:  if (mem_ready_i) nxt = S_SV_WP;
            S_SV_WP:   if (mem_ready_i) nxt = S_SV_PC;
            S_SV_PC:   if (mem_ready_i) nxt = S_SV_ST;
            S_SV_ST:   if (mem_ready_i) nxt = (op_q == OP_EXTOP) ? S_SV_LINK : S_COMMIT;
            S_SV_LINK: if (mem_ready_i) nxt = S_COMMIT;
            S_LD_WP:   if (mem_ready_i) nxt = S_LD_PC;
            S_LD_PC:   if (mem_ready_i) nxt = S_LD_ST;
            S_LD_ST:   if (mem_ready_i) nxt = S_COMMIT;
            S_LINK:    if (mem_ready_i) nxt = S_COMMIT;
            S_COMMIT:  nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // operand capture and words gathered along the sequence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_SWAP_WS;
            opnd_q <= '0;
            vec_q  <= '0;
            nwp_q  <= '0;
            npc_q  <= '0;
            nst_q  <= '0;
        end else if (accept) begin
            op_q   <= ctx_op_e'(op_i);
            opnd_q <= opnd_i;
            vec_q  <= vec_i;
            nwp_q  <= wp_i;
            npc_q  <= (op_i == OP_CALL) ? opnd_i : pc_i;
            nst_q  <= st_calc;
        end else if (mem_ready_i) begin
            unique case (state)
                S_VEC_WP, S_LD_WP: nwp_q <= mem_rdata_i;
                S_VEC_PC, S_LD_PC: npc_q <= mem_rdata_i;
                S_LD_ST:           nst_q <= mem_rdata_i;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_addr_o  = '0;
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_wdata_o = '0;
        commit_o    = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_VEC_WP: begin
                mem_addr_o = vec_q;
                mem_rd_o   = 1'b1;
            end
            S_VEC_PC: begin
                mem_addr_o = vec_q + W'(2);
                mem_rd_o   = 1'b1;
            end
            S_SV_WP: begin
                mem_addr_o  = nwp_q + OFF_SWP;
                mem_wr_o    = 1'b1;
                mem_wdata_o = wp_i;
            end
            S_SV_PC: begin
                mem_addr_o  = nwp_q + OFF_SPC;
                mem_wr_o    = 1'b1;
                mem_wdata_o = pc_i;
            end
            S_SV_ST: begin
                mem_addr_o  = nwp_q + OFF_SST;
                mem_wr_o    = 1'b1;
                mem_wdata_o = st_i;
            end
            S_SV_LINK: begin
                mem_addr_o  = nwp_q + OFF_LINK;
                mem_wr_o    = 1'b1;
                mem_wdata_o = opnd_q;
            end
            S_LD_WP: begin
                mem_addr_o = wp_i + OFF_SWP;
                mem_rd_o   = 1'b1;
            end
            S_LD_PC: begin
                mem_addr_o = wp_i + OFF_SPC;
                mem_rd_o   = 1'b1;
            end
            S_LD_ST: begin
                mem_addr_o = wp_i + OFF_SST;
                mem_rd_o   = 1'b1;
            end
            S_LINK: begin
                mem_addr_o  = wp_i + OFF_LINK;
                mem_wr_o    = 1'b1;
                mem_wdata_o = pc_i;
            end
            S_COMMIT: commit_o = 1'b1;
            default: ;
        endcase
    end

    assign new_pc_o = npc_q;
    assign new_wp_o = nwp_q;
    assign new_st_o = nst_q;
    assign busy_o   = (state != S_IDLE);

endmodule

// File: rtl/wsctx_seq.sv
module wsctx_seq
    import ctx_pkg::*;
#(
    parameter int           W         = 16,
    parameter int           CNT_W     = MASK_W,
    parameter int           LINK_REG  = 11,
    parameter int           SAVE_REG  = 13,
    parameter logic [W-1:0] XOP_BASE  = 16'h0040,
    parameter logic [W-1:0] IRQ_BASE  = 16'h0000,
    parameter logic [W-1:0] RESTART_V = 16'hFFFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       op_i,
    input  logic [W-1:0]     addr_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [W-1:0]     mem_addr_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic [W-1:0]     mem_wdata_o,
    input  logic [W-1:0]     mem_rdata_i,
    input  logic             mem_ready_i,
    output logic [W-1:0]     pc_o,
    output logic [W-1:0]     wp_o,
    output logic [W-1:0]     st_o,
    output logic             busy_o,
    output logic             done_o
);

    logic [W-1:0] vec;
    logic [W-1:0] new_pc, new_wp, new_st;
    logic         commit;

    ctx_vector #(
        .W(W), .CNT_W(CNT_W), .XOP_BASE(XOP_BASE),
        .IRQ_BASE(IRQ_BASE), .RESTART_V(RESTART_V)
    ) u_vec (
        .op_i   (op_i),
        .opnd_i (addr_i),
        .cnt_i  (cnt_i),
        .vec_o  (vec)
    );

    ctx_seq_fsm #(
        .W(W), .CNT_W(CNT_W), .LINK_REG(LINK_REG), .SAVE_REG(SAVE_REG)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .op_i        (op_i),
        .opnd_i      (addr_i),
        .cnt_i       (cnt_i),
        .vec_i       (vec),
        .pc_i        (pc_o),
        .wp_i        (wp_o),
        .st_i        (st_o),
        .mem_rdata_i (mem_rdata_i),
        .mem_ready_i (mem_ready_i),
        .mem_addr_o  (mem_addr_o),
        .mem_rd_o    (mem_rd_o),
        .mem_wr_o    (mem_wr_o),
        .mem_wdata_o (mem_wdata_o),
        .commit_o    (commit),
        .new_pc_o    (new_pc),
        .new_wp_o    (new_wp),
        .new_st_o    (new_st),
        .busy_o      (busy_o)
    );

    ctx_arch_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .new_pc_i (new_pc),
        .new_wp_i (new_wp),
        .new_st_i (new_st),
        .pc_o     (pc_o),
        .wp_o     (wp_o),
        .st_o     (st_o)
    );

    assign done_o = commit;

endmodule

// File: rtl/wsctx_chk.sv
module wsctx_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [W-1:0] mem_addr_o,
    input logic         mem_rd_o,
    input logic         mem_wr_o,
    input logic [W-1:0] mem_wdata_o,
    input logic         mem_ready_i,
    input logic [W-1:0] pc_o,
    input logic [W-1:0] wp_o,
    input logic [W-1:0] st_o,
    input logic         busy_o,
    input logic         done_o
);

    assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    assert_hold_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd_o || mem_wr_o) && !mem_ready_i) |=>
            (mem_rd_o == $past(mem_rd_o)) && (mem_wr_o == $past(mem_wr_o)) &&
            $stable(mem_addr_o) && (!mem_wr_o || $stable(mem_wdata_o)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_regs_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> $stable(pc_o) && $stable(wp_o) && $stable(st_o));

    assert_idle_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |-> !(mem_rd_o || mem_wr_o) && !done_o);

    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

endmodule

bind wsctx_seq wsctx_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ready_i (mem_ready_i),
    .pc_o        (pc_o),
    .wp_o        (wp_o),
    .st_o        (st_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/sim_wsctx_seq.sv
`timescale 1ns/1ps
module sim_wsctx_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [15:0] addr_i = '0;
    logic [3:0]  cnt_i = '0;
    logic [15:0] mem_addr_o, mem_wdata_o, pc_o, wp_o, st_o;
    logic        mem_rd_o, mem_wr_o, busy_o, done_o;
    logic [15:0] mem_rdata_i = '0;
    logic        mem_ready_i = 1'b0;

    always #2.5 clk = ~clk;

    wsctx_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .addr_i(addr_i), .cnt_i(cnt_i),
        .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .mem_ready_i(mem_ready_i),
        .pc_o(pc_o), .wp_o(wp_o), .st_o(st_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [15:0] data;
    } acc_t;

    acc_t        exp_q[$];
    logic [15:0] mem [int unsigned];
    int          errors = 0;
    int          checks = 0;
    string       cur_tag = "R1";
    logic [15:0] e_pc = 0, e_wp = 0, e_st = 0;

    function automatic logic [15:0] mrd(logic [15:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // memory model and scoreboard monitor
    int          n_acc = 0;
    int          wait_left = 0;
    bit          was_waiting = 0;
    logic [15:0] wait_addr = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready_i = 1'b0;
            was_waiting = 0;
        end else if (mem_rd_o || mem_wr_o) begin
            chk(!(mem_rd_o && mem_wr_o), "R12", "both strobes", {15'd0, mem_wr_o}, 16'h0);
            if (was_waiting)
                chk(mem_addr_o == wait_addr, "R9", "address moved while waiting",
                    mem_addr_o, wait_addr);
            if (wait_left == 0) begin
                if (exp_q.size() == 0) begin
                    chk(0, cur_tag, "unexpected access", mem_addr_o, 16'h0);
                end else begin
                    acc_t e;
                    e = exp_q.pop_front();
                    chk(mem_wr_o == e.wr, cur_tag, "access kind", {15'd0, mem_wr_o}, {15'd0, e.wr});
                    chk(mem_addr_o == e.addr, cur_tag, "access address", mem_addr_o, e.addr);
                    if (e.wr)
                        chk(mem_wdata_o == e.data, cur_tag, "write data", mem_wdata_o, e.data);
                end
                if (mem_rd_o) mem_rdata_i = mrd(mem_addr_o);
                if (mem_wr_o) mem[int'(mem_addr_o)] = mem_wdata_o;
                mem_ready_i = 1'b1;
                was_waiting = 0;
                n_acc++;
                wait_left = n_acc % 3;
            end else begin
                mem_ready_i = 1'b0;
                was_waiting = 1;
                wait_addr   = mem_addr_o;
                wait_left--;
            end
        end else begin
            mem_ready_i = 1'b0;
            was_waiting = 0;
        end
    end

    function automatic void push(input logic wr, input logic [15:0] a, input logic [15:0] d);
        acc_t e;
        e.wr = wr; e.addr = a; e.data = d;
        exp_q.push_back(e);
    endfunction

    // driver: builds the expected access list and register result
    task automatic run_op(input logic [2:0] op, input logic [15:0] s,
                          input logic [3:0] c, input string tag, input bit inject);
        logic [15:0] vec, nwp, npc, nst;
        int t;
        cur_tag = tag;
        nst = e_st;
        nwp = e_wp;
        npc = e_pc;
        if (op == 3'd1) begin
            push(0, e_wp + 16'd26, 0);
            push(0, e_wp + 16'd28, 0);
            push(0, e_wp + 16'd30, 0);
            nwp = mrd(e_wp + 16'd26);
            npc = mrd(e_wp + 16'd28);
            nst = mrd(e_wp + 16'd30);
        end else if (op == 3'd5) begin
            push(1, e_wp + 16'd22, e_pc);
            npc = s;
        end else begin
            case (op)
                3'd2:    vec = 16'h0040 + 16'(c) * 16'd4;
                3'd3:    vec = 16'(c) * 16'd4;
                3'd4:    vec = 16'hFFFC;
                default: vec = s;
            endcase
            push(0, vec, 0);
            push(0, vec + 16'd2, 0);
            nwp = mrd(vec);
            npc = mrd(vec + 16'd2);
            push(1, nwp + 16'd26, e_wp);
            push(1, nwp + 16'd28, e_pc);
            push(1, nwp + 16'd30, e_st);
            if (op == 3'd2) begin
                push(1, nwp + 16'd22, s);
                nst[9] = 1'b1;
            end
            if (op == 3'd3) nst[3:0] = (c == 0) ? 4'd0 : c - 4'd1;
        end
        op_i = op; addr_i = s; cnt_i = c; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (inject) begin
            @(negedge clk);
            op_i = 3'd1; start_i = 1'b1;   // R11: second start while busy
            @(negedge clk);
            start_i = 1'b0;
        end
        t = 0;
        while (!done_o && t < 400) begin
            @(negedge clk);
            t++;
        end
        chk(done_o, tag, "done seen", {15'd0, done_o}, 16'h1);
        chk(pc_o == e_pc, "R10", "pc before commit edge", pc_o, e_pc);
        @(negedge clk);
        chk(!done_o, "R10", "done width", {15'd0, done_o}, 16'h0);
        chk(exp_q.size() == 0, tag, "accesses left", 16'(exp_q.size()), 16'h0);
        exp_q.delete();
        chk(pc_o == npc, tag, "pc", pc_o, npc);
        chk(wp_o == nwp, tag, "wp", wp_o, nwp);
        chk(st_o == nst, tag, "st", st_o, nst);
        e_pc = npc; e_wp = nwp; e_st = nst;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #200us;
        errors++;
        $display("FAIL watchdog expired during %s", cur_tag);
        summary();
    end

    initial begin
        mem[32'h0100] = 16'h0200; mem[32'h0102] = 16'h0300;   // swap vector
        mem[32'h000C] = 16'h0400; mem[32'h000E] = 16'h0500;   // level 3
        mem[32'h0048] = 16'h0600; mem[32'h004A] = 16'h0700;   // ext count 2
        mem[32'hFFFC] = 16'h0800; mem[32'hFFFE] = 16'h0900;   // restart
        mem[32'h0000] = 16'h0A00; mem[32'h0002] = 16'h0B00;   // level 0
        mem[32'h007C] = 16'h0C00; mem[32'h007E] = 16'h0D00;   // ext count 15
        mem[32'h003C] = 16'h0E00; mem[32'h003E] = 16'h0F00;   // level 15
        mem[32'h0120] = 16'h1000; mem[32'h0122] = 16'h1100;   // second swap

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pc_o == 0 && wp_o == 0 && st_o == 0, "R1", "regs after reset", pc_o | wp_o | st_o, 16'h0);
        chk(!mem_rd_o && !mem_wr_o && !busy_o && !done_o, "R1", "controls after reset",
            {12'd0, mem_rd_o, mem_wr_o, busy_o, done_o}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(3'd0, 16'h0100, 4'd0, "R2", 0);    // R2 and R3 saves
        run_op(3'd3, 16'h0000, 4'd3, "R6", 0);
        run_op(3'd2, 16'h1234, 4'd2, "R5", 0);
        run_op(3'd1, 16'h0000, 4'd0, "R4", 0);
        run_op(3'd5, 16'h0ABC, 4'd0, "R8", 0);
        run_op(3'd4, 16'h0000, 4'd0, "R7", 0);
        run_op(3'd3, 16'h0000, 4'd0, "R6", 0);
        run_op(3'd2, 16'h5678, 4'd15, "R5", 0);
        run_op(3'd3, 16'h0000, 4'd15, "R6", 0);
        run_op(3'd0, 16'h0120, 4'd0, "R3", 0);
        run_op(3'd0, 16'h0100, 4'd0, "R11", 1);   // start while busy ignored

        // R11: undefined op codes start nothing
        cur_tag = "R11";
        for (int k = 6; k < 8; k++) begin
            op_i = 3'(k); start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            for (int j = 0; j < 6; j++) begin
                @(negedge clk);
                chk(!busy_o && !done_o, "R11", "undefined op reacted",
                    {14'd0, busy_o, done_o}, 16'h0);
            end
            chk(pc_o == e_pc && wp_o == e_wp && st_o == e_st, "R11", "regs after undefined op",
                pc_o, e_pc);
        end
        summary();
    end

endmodule